// File: doc/BRIEF.md
# Flash program request checker

This block guards the command path to a non-volatile memory array. Software configures an operation through a 32-bit control register: programming enable, sector erase, mass erase, a target sector number, a programming width selection and two interrupt enables. A lock bit protects that register and is set after reset. An unlock strobe clears it. Writing 1 to the lock bit sets it again.

Each program access arrives with an address and a size. The block checks the access before anything reaches the array. The size must match the selected width. The data must fit inside one 128-bit row. The target sector must not be write protected, and erases are checked against the same protection. An access that fails a check never reaches the array. Instead it raises sticky error flags in a status register. An accepted access produces a one-cycle start pulse toward the array model and holds the block busy until the model returns a done pulse. Completion and rejection are reported through flags that software clears by writing 1. The operation-error and completion flags are only set when their enables are on.

Top module: `npg_top`

## Requirements
- R1: After reset the control register reads 0x8000_0000, the status register reads 0 and no start pulse is issued.
- R2: While control bit 31 (lock) is 1, writes to the control register are ignored and program accesses are ignored. A one-cycle `unlock` pulse clears the lock. A control write with bit 31 set, made while unlocked, sets it again.
- R3: Control fields sit at bit 31 lock, bit 25 error enable, bit 24 completion enable, bit 16 start, bits 9:8 width selection, bits 6:3 sector number, bit 2 mass erase, bit 1 sector erase and bit 0 program enable. All other control bits read 0.
- R4: `prog_size` and the width field share one encoding: 0 byte, 1 half-word, 2 word, 3 double word. A program access whose size differs from the width field sets status bit 6.
- R5: A program access whose address bits 3:0 plus its byte count exceed 16 sets status bit 5. An access ending exactly at the row boundary is accepted.
- R6: Status bit 4 is set by any of three rejected requests: a program access whose sector (address bits 17:14) is 12 or more or is marked in `wp_mask`; a sector erase whose sector number is 12 or more or is marked; or a mass erase while any `wp_mask` bit is 1.
- R7: An accepted request produces a single-cycle `arr_start` on the clock after acceptance. With it come `arr_op` (1 program, 2 sector erase, 3 mass erase) and `arr_sector` (0 for mass erase). A rejected request produces no start. No request is accepted while an operation is in flight; the operation ends with `arr_done`.
- R8: Status bit 1 is set alongside any rejection only when the error enable is 1.
- R9: Status bit 0 is set by `arr_done` ending an operation only when the completion enable is 1.
- R10: Writing 1 to status bits 6, 5, 4, 1 or 0 clears them and writing 0 leaves them unchanged. A hardware set in the same cycle as a clear wins.
- R11: Status bits other than 6, 5, 4, 1 and 0 always read 0.
- R12: A control write sets the start bit only if the written value also has sector erase or mass erase set, the block is idle and start is 0. Start clears when the erase ends or is rejected. Mass erase takes precedence over sector erase, and a pending erase takes precedence over a program access.
- R13: Program accesses are ignored while the program enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 status, 1 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| unlock | input | 1 | Abstract unlock strobe, clears the lock |
| wp_mask | input | 12 | Per-sector write-protection mask |
| prog_valid | input | 1 | Program access present this cycle |
| prog_addr | input | 18 | Byte address of the program access |
| prog_size | input | 2 | Access size code |
| arr_done | input | 1 | Array operation finished |
| arr_start | output | 1 | One-cycle operation start to the array |
| arr_op | output | 2 | Operation kind, valid with arr_start |
| arr_sector | output | 4 | Target sector, valid with arr_start |

## Verification
Two pairs of events can land on the same edge. In the first, a software write-1-to-clear on the status register meets a hardware flag set. The bench drives `arr_done` and a status write that clears bit 0 in the same cycle. It then expects bit 0 to read 1. In the second, a control write that arms an erase meets a program access accepted on that edge. A behavioural reference model follows both cases every clock. It handles them by evaluating the array-side events against the register values from before the edge. Each register readout and start pulse is then compared against that model.

// File: rtl/npg_pkg.sv
package npg_pkg;

    localparam int CB_LOCK   = 31;
    localparam int CB_ERRIE  = 25;
    localparam int CB_DONEIE = 24;
    localparam int CB_START  = 16;
    localparam int CB_WIDTH  = 8;
    localparam int CB_SECT   = 3;
    localparam int CB_MASS   = 2;
    localparam int CB_SERASE = 1;
    localparam int CB_PROG   = 0;

    localparam int SB_WIDTH  = 6;
    localparam int SB_ROW    = 5;
    localparam int SB_PROT   = 4;
    localparam int SB_REJ    = 1;
    localparam int SB_DONE   = 0;

    localparam int          SECT_FIELD_W = 4;
    localparam logic [31:0] CTRL_INIT    = 32'h8000_0000;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_SECT  = 2'd2,
        OP_MASS  = 2'd3
    } op_e;

    typedef struct packed {
        logic                    lock;
        logic                    err_en;
        logic                    done_en;
        logic                    start;
        logic [1:0]              width;
        logic [SECT_FIELD_W-1:0] sect;
        logic                    mass;
        logic                    serase;
        logic                    prog;
    } ctrl_t;

    typedef struct packed {
        logic width;
        logic row;
        logic prot;
    } fault_t;

    typedef struct packed {
        logic width;
        logic row;
        logic prot;
        logic rej;
        logic done;
    } flags_t;

    function automatic ctrl_t word_to_ctrl(logic [31:0] w);
        ctrl_t c;
        c.lock    = w[CB_LOCK];
        c.err_en  = w[CB_ERRIE];
        c.done_en = w[CB_DONEIE];
        c.start   = w[CB_START];
        c.width   = w[CB_WIDTH +: 2];
        c.sect    = w[CB_SECT +: SECT_FIELD_W];
        c.mass    = w[CB_MASS];
        c.serase  = w[CB_SERASE];
        c.prog    = w[CB_PROG];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_to_word(ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[CB_LOCK]                 = c.lock;
        w[CB_ERRIE]                = c.err_en;
        w[CB_DONEIE]               = c.done_en;
        w[CB_START]                = c.start;
        w[CB_WIDTH +: 2]           = c.width;
        w[CB_SECT +: SECT_FIELD_W] = c.sect;
        w[CB_MASS]                 = c.mass;
        w[CB_SERASE]               = c.serase;
        w[CB_PROG]                 = c.prog;
        return w;
    endfunction

    function automatic flags_t word_to_flags(logic [31:0] w);
        flags_t f;
        f.width = w[SB_WIDTH];
        f.row   = w[SB_ROW];
        f.prot  = w[SB_PROT];
        f.rej   = w[SB_REJ];
        f.done  = w[SB_DONE];
        return f;
    endfunction

    function automatic logic [31:0] flags_to_word(flags_t f);
        logic [31:0] w;
        w = '0;
        w[SB_WIDTH] = f.width;
        w[SB_ROW]   = f.row;
        w[SB_PROT]  = f.prot;
        w[SB_REJ]   = f.rej;
        w[SB_DONE]  = f.done;
        return w;
    endfunction

    function automatic logic any_fault(fault_t f);
        return f.width | f.row | f.prot;
    endfunction

endpackage

// File: rtl/npg_ctrl_reg.sv
module npg_ctrl_reg
    import npg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    input  logic        unlock,
    input  logic        seq_busy,
    input  logic        start_clr,
    output ctrl_t       ctrl_q
);

    ctrl_t wf;
    logic  wr_ok;
    logic  start_set;

    always_comb begin
        wf        = word_to_ctrl(wdata);
        wr_ok     = wr_en & ~ctrl_q.lock;
        start_set = wr_ok & wf.start & (wf.mass | wf.serase) & ~seq_busy & ~ctrl_q.start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= word_to_ctrl(CTRL_INIT);
        end else begin
            if (ctrl_q.lock) begin
                if (unlock) begin
                    ctrl_q.lock <= 1'b0;
                end
            end else if (wr_en) begin
                ctrl_q.lock    <= wf.lock;
                ctrl_q.err_en  <= wf.err_en;
                ctrl_q.done_en <= wf.done_en;
                ctrl_q.width   <= wf.width;
                ctrl_q.sect    <= wf.sect;
                ctrl_q.mass    <= wf.mass;
                ctrl_q.serase  <= wf.serase;
                ctrl_q.prog    <= wf.prog;
            end
            if (start_set) begin
                ctrl_q.start <= 1'b1;
            end else if (start_clr) begin
                ctrl_q.start <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/npg_access_check.sv
module npg_access_check
    import npg_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int SECT_LOG2 = 14,
    parameter int NUM_SECT  = 12,
    parameter int ROW_LOG2  = 4
) (
    input  ctrl_t                        ctrl,
    input  logic [ADDR_W-1:0]            prog_addr,
    input  logic [1:0]                   prog_size,
    input  logic [NUM_SECT-1:0]          wp_mask,
    output fault_t                       prog_fault,
    output fault_t                       erase_fault,
    output logic [ADDR_W-SECT_LOG2-1:0]  prog_sector
);

    localparam int SEC_W     = ADDR_W - SECT_LOG2;
    localparam int ADDR_SPAN = 1 << SEC_W;
    localparam int FLD_SPAN  = 1 << SECT_FIELD_W;
    localparam int SUM_W     = ROW_LOG2 + 5;
    localparam int ROW_BYTES = 1 << ROW_LOG2;

    logic [ADDR_SPAN-1:0] guard_addr;
    logic [FLD_SPAN-1:0]  guard_fld;
    logic [SUM_W-1:0]     reach;

    for (genvar i = 0; i < ADDR_SPAN; i++) begin : g_addr_guard
        if (i < NUM_SECT) begin : g_real
            assign guard_addr[i] = wp_mask[i];
        end else begin : g_absent
            assign guard_addr[i] = 1'b1;
        end
    end

    for (genvar j = 0; j < FLD_SPAN; j++) begin : g_fld_guard
        if (j < NUM_SECT) begin : g_real
            assign guard_fld[j] = wp_mask[j];
        end else begin : g_absent
            assign guard_fld[j] = 1'b1;
        end
    end

    always_comb begin
        prog_sector      = prog_addr[ADDR_W-1:SECT_LOG2];
        reach            = SUM_W'(prog_addr[ROW_LOG2-1:0]) + (SUM_W'(1) << prog_size);
        prog_fault.width = (prog_size != ctrl.width);
        prog_fault.row   = (reach > SUM_W'(ROW_BYTES));
        prog_fault.prot  = guard_addr[prog_sector];

        erase_fault.width = 1'b0;
        erase_fault.row   = 1'b0;
        erase_fault.prot  = ctrl.mass ? (|wp_mask) : guard_fld[ctrl.sect];
    end

endmodule

// File: rtl/npg_seq.sv
module npg_seq
    import npg_pkg::*;
#(
    parameter int SEC_W = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  ctrl_t                   ctrl,
    input  logic                    prog_valid,
    input  fault_t                  prog_fault,
    input  fault_t                  erase_fault,
    input  logic [SEC_W-1:0]        prog_sector,
    input  logic                    arr_done,
    output logic                    busy,
    output logic                    start_clr,
    output flags_t                  hw_set,
    output logic                    arr_start,
    output op_e                     arr_op,
    output logic [SECT_FIELD_W-1:0] arr_sector
);

    logic erase_go, prog_go;
    logic erase_rej, erase_acc, prog_rej, prog_acc;
    logic done_ev;
    op_e  next_op;
    logic [SECT_FIELD_W-1:0] next_sector;

    always_comb begin
        erase_go  = ~busy & ctrl.start;
        prog_go   = ~busy & ~ctrl.start & prog_valid & ctrl.prog & ~ctrl.lock;
        erase_rej = erase_go & any_fault(erase_fault);
        erase_acc = erase_go & ~any_fault(erase_fault);
        prog_rej  = prog_go & any_fault(prog_fault);
        prog_acc  = prog_go & ~any_fault(prog_fault);
        done_ev   = busy & arr_done;

        hw_set.width = prog_rej & prog_fault.width;
        hw_set.row   = prog_rej & prog_fault.row;
        hw_set.prot  = (prog_rej & prog_fault.prot) | (erase_rej & erase_fault.prot);
        hw_set.rej   = (prog_rej | erase_rej) & ctrl.err_en;
        hw_set.done  = done_ev & ctrl.done_en;

        start_clr = erase_rej | (done_ev & (arr_op != OP_PROG));

        if (erase_acc) begin
            next_op     = ctrl.mass ? OP_MASS : OP_SECT;
            next_sector = ctrl.mass ? '0 : ctrl.sect;
        end else begin
            next_op     = OP_PROG;
            next_sector = SECT_FIELD_W'(prog_sector);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            arr_start  <= 1'b0;
            arr_op     <= OP_NONE;
            arr_sector <= '0;
        end else begin
            arr_start <= erase_acc | prog_acc;
            if (erase_acc | prog_acc) begin
                busy       <= 1'b1;
                arr_op     <= next_op;
                arr_sector <= next_sector;
            end else if (done_ev) begin
                busy       <= 1'b0;
                arr_op     <= OP_NONE;
                arr_sector <= '0;
            end
        end
    end

endmodule

// File: rtl/npg_status.sv
module npg_status
    import npg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr_en,
    input  logic [31:0] wdata,
    input  flags_t      hw_set,
    output flags_t      flags_q
);

    flags_t clr;

    always_comb begin
        clr = clr_en ? word_to_flags(wdata) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~clr) | hw_set;
        end
    end

endmodule

// File: rtl/npg_top.sv
module npg_top
    import npg_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int SECT_LOG2 = 14,
    parameter int NUM_SECT  = 12,
    parameter int ROW_LOG2  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic                reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                unlock,
    input  logic [NUM_SECT-1:0] wp_mask,
    input  logic                prog_valid,
    input  logic [ADDR_W-1:0]   prog_addr,
    input  logic [1:0]          prog_size,
    input  logic                arr_done,
    output logic                arr_start,
    output logic [1:0]          arr_op,
    output logic [3:0]          arr_sector
);

    localparam int SEC_W = ADDR_W - SECT_LOG2;

    ctrl_t             ctrl_q;
    flags_t            flags_q;
    flags_t            hw_set;
    fault_t            prog_fault;
    fault_t            erase_fault;
    logic [SEC_W-1:0]  prog_sector;
    logic              busy;
    logic              start_clr;
    op_e               op_q;
    logic [31:0]       ctrl_word;
    logic [31:0]       status_word;

    npg_ctrl_reg i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr & reg_addr),
        .wdata     (reg_wdata),
        .unlock    (unlock),
        .seq_busy  (busy),
        .start_clr (start_clr),
        .ctrl_q    (ctrl_q)
    );

    npg_access_check #(
        .ADDR_W    (ADDR_W),
        .SECT_LOG2 (SECT_LOG2),
        .NUM_SECT  (NUM_SECT),
        .ROW_LOG2  (ROW_LOG2)
    ) i_check (
        .ctrl        (ctrl_q),
        .prog_addr   (prog_addr),
        .prog_size   (prog_size),
        .wp_mask     (wp_mask),
        .prog_fault  (prog_fault),
        .erase_fault (erase_fault),
        .prog_sector (prog_sector)
    );

    npg_seq #(
        .SEC_W (SEC_W)
    ) i_seq (
        .clk         (clk),
        .rst         (rst),
        .ctrl        (ctrl_q),
        .prog_valid  (prog_valid),
        .prog_fault  (prog_fault),
        .erase_fault (erase_fault),
        .prog_sector (prog_sector),
        .arr_done    (arr_done),
        .busy        (busy),
        .start_clr   (start_clr),
        .hw_set      (hw_set),
        .arr_start   (arr_start),
        .arr_op      (op_q),
        .arr_sector  (arr_sector)
    );

    npg_status i_status (
        .clk     (clk),
        .rst     (rst),
        .clr_en  (reg_wr & ~reg_addr),
        .wdata   (reg_wdata),
        .hw_set  (hw_set),
        .flags_q (flags_q)
    );

    always_comb begin
        ctrl_word   = ctrl_to_word(ctrl_q);
        status_word = flags_to_word(flags_q);
        reg_rdata   = reg_addr ? ctrl_word : status_word;
        arr_op      = op_q;
    end

endmodule

// File: rtl/npg_checker.sv
module npg_checker (
    input logic        clk,
    input logic        rst,
    input logic [31:0] ctrl_word,
    input logic [31:0] status_word,
    input logic        reg_wr,
    input logic        reg_addr,
    input logic        unlock,
    input logic        busy,
    input logic        arr_start,
    input logic        arr_done
);

    // R1: lock is set once reset has been applied
    a_r1_lock_after_reset: assert property (@(posedge clk)
        rst |=> ctrl_word[31]);

    // R2: a control write while locked changes no configuration field
    a_r2_locked_write: assert property (@(posedge clk) disable iff (rst)
        (ctrl_word[31] && reg_wr && reg_addr && !unlock)
        |=> (ctrl_word[31] && $stable(ctrl_word[25:24]) && $stable(ctrl_word[9:0])));

    // R7: start is a single-cycle pulse
    a_r7_start_pulse: assert property (@(posedge clk) disable iff (rst)
        arr_start |=> !arr_start);

    // R7: no start is issued from a busy state
    a_r7_no_start_busy: assert property (@(posedge clk) disable iff (rst)
        arr_start |-> !$past(busy));

    // R8: rejection flag only rises with the error enable on
    a_r8_rej_gated: assert property (@(posedge clk) disable iff (rst)
        $rose(status_word[1]) |-> $past(ctrl_word[25]));

    // R9: completion flag only rises on done with its enable on
    a_r9_done_gated: assert property (@(posedge clk) disable iff (rst)
        $rose(status_word[0]) |-> ($past(ctrl_word[24]) && $past(arr_done)));

    // R11: unused status bits stay zero
    a_r11_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (status_word & ~32'h0000_0073) == 32'h0);

endmodule

bind npg_top npg_checker i_npg_checker (
    .clk         (clk),
    .rst         (rst),
    .ctrl_word   (ctrl_word),
    .status_word (status_word),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .unlock      (unlock),
    .busy        (busy),
    .arr_start   (arr_start),
    .arr_done    (arr_done)
);

// File: tb/test_npg_top.sv
module test_npg_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        unlock = 1'b0;
    logic [11:0] wp_mask = '0;
    logic        prog_valid = 1'b0;
    logic [17:0] prog_addr = '0;
    logic [1:0]  prog_size = '0;
    logic        arr_done = 1'b0;
    logic        arr_start;
    logic [1:0]  arr_op;
    logic [3:0]  arr_sector;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    npg_top i_npg_top (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .unlock     (unlock),
        .wp_mask    (wp_mask),
        .prog_valid (prog_valid),
        .prog_addr  (prog_addr),
        .prog_size  (prog_size),
        .arr_done   (arr_done),
        .arr_start  (arr_start),
        .arr_op     (arr_op),
        .arr_sector (arr_sector)
    );

    // Behavioural reference model
    logic       m_lock, m_erren, m_doneen, m_start_bit, m_mass, m_serase, m_prog;
    logic [1:0] m_width;
    logic [3:0] m_sect;
    logic       m_busy;
    logic [1:0] m_op;
    logic [3:0] m_osect;
    logic       m_pulse;
    logic [6:0] m_flags;

    function automatic logic [31:0] model_ctrl();
        logic [31:0] w;
        w = 32'h0;
        w[31] = m_lock; w[25] = m_erren; w[24] = m_doneen; w[16] = m_start_bit;
        w[9:8] = m_width; w[6:3] = m_sect; w[2] = m_mass; w[1] = m_serase; w[0] = m_prog;
        return w;
    endfunction

    always @(posedge clk) begin
        logic ob, os, ol, sclr, sset, prot;
        logic [6:0] setv;
        int sec, reach;
        if (rst) begin
            m_lock = 1; m_erren = 0; m_doneen = 0; m_start_bit = 0;
            m_mass = 0; m_serase = 0; m_prog = 0; m_width = 0; m_sect = 0;
            m_busy = 0; m_op = 0; m_osect = 0; m_pulse = 0; m_flags = 0;
        end else begin
            ob = m_busy; os = m_start_bit; ol = m_lock;
            sclr = 0; sset = 0; setv = 0; m_pulse = 0;
            if (!ob) begin
                if (os) begin
                    if (m_mass) prot = (wp_mask != 0);
                    else prot = (m_sect >= 12) || wp_mask[m_sect];
                    if (prot) begin
                        setv[4] = 1; setv[1] = m_erren; sclr = 1;
                    end else begin
                        m_pulse = 1; m_busy = 1;
                        m_op = m_mass ? 2'd3 : 2'd2;
                        m_osect = m_mass ? 4'd0 : m_sect;
                    end
                end else if (prog_valid && m_prog && !ol) begin
                    sec = int'(prog_addr >> 14);
                    reach = int'(prog_addr % 16) + (1 << prog_size);
                    setv[6] = (prog_size != m_width);
                    setv[5] = (reach > 16);
                    setv[4] = (sec >= 12) || wp_mask[sec];
                    if (setv[6] || setv[5] || setv[4]) begin
                        setv[1] = m_erren;
                    end else begin
                        m_pulse = 1; m_busy = 1; m_op = 2'd1; m_osect = 4'(sec);
                    end
                end
            end else if (arr_done) begin
                m_busy = 0; setv[0] = m_doneen;
                if (m_op != 2'd1) sclr = 1;
                m_op = 0;
            end
            if (reg_wr && !reg_addr) m_flags = m_flags & ~(reg_wdata[6:0] & 7'h73);
            m_flags = m_flags | setv;
            if (ol) begin
                if (unlock) m_lock = 0;
            end else if (reg_wr && reg_addr) begin
                m_lock = reg_wdata[31]; m_erren = reg_wdata[25]; m_doneen = reg_wdata[24];
                m_width = reg_wdata[9:8]; m_sect = reg_wdata[6:3];
                m_mass = reg_wdata[2]; m_serase = reg_wdata[1]; m_prog = reg_wdata[0];
                sset = reg_wdata[16] && (reg_wdata[2] || reg_wdata[1]) && !ob && !os;
            end
            if (sset) m_start_bit = 1;
            else if (sclr) m_start_bit = 0;
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            total++;
            if (reg_addr && reg_rdata !== model_ctrl()) begin
                bad++;
                $display("FAIL R3 model control: actual=%h expected=%h", reg_rdata, model_ctrl());
            end
            if (!reg_addr && reg_rdata !== {25'h0, m_flags}) begin
                bad++;
                $display("FAIL R10 model status: actual=%h expected=%h", reg_rdata, {25'h0, m_flags});
            end
            total++;
            if (arr_start !== m_pulse) begin
                bad++;
                $display("FAIL R7 model start: actual=%b expected=%b", arr_start, m_pulse);
            end else if (m_pulse && (arr_op !== m_op || arr_sector !== m_osect)) begin
                bad++;
                $display("FAIL R7 model op/sector: actual=%0d/%0d expected=%0d/%0d",
                         arr_op, arr_sector, m_op, m_osect);
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic prog(input logic [17:0] a, input logic [1:0] s);
        @(posedge clk); #1;
        prog_valid = 1; prog_addr = a; prog_size = s;
        @(posedge clk); #1;
        prog_valid = 0;
    endtask

    task automatic done_pulse();
        @(posedge clk); #1;
        arr_done = 1;
        @(posedge clk); #1;
        arr_done = 0;
    endtask

    task automatic expect_start(input string tag, input logic exp, input logic [1:0] exp_op,
                                input logic [3:0] exp_sec);
        logic found;
        logic [1:0] op;
        logic [3:0] sc;
        found = 0; op = 0; sc = 0;
        repeat (4) begin
            @(negedge clk);
            if (arr_start) begin found = 1; op = arr_op; sc = arr_sector; end
        end
        check({tag, " start"}, {31'h0, found}, {31'h0, exp});
        if (exp) check({tag, " op/sector"}, {26'h0, op, sc}, {26'h0, exp_op, exp_sec});
    endtask

    task automatic clear_all();
        wr(1'b0, 32'h0000_0073);
    endtask

    logic [31:0] v;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        rd(1'b1, v); check("R1 control reset", v, 32'h8000_0000);
        rd(1'b0, v); check("R1 status reset", v, 32'h0);
        check("R1 no start", {31'h0, arr_start}, 32'h0);

        wr(1'b1, 32'h0000_0201);
        rd(1'b1, v); check("R2 locked write ignored", v, 32'h8000_0000);
        @(posedge clk); #1 unlock = 1;
        @(posedge clk); #1 unlock = 0;
        rd(1'b1, v); check("R2 unlock", v, 32'h0);

        wr(1'b1, 32'h0300_0201);
        rd(1'b1, v); check("R3 field layout", v, 32'h0300_0201);
        wr(1'b1, 32'h7CFE_FC80);
        rd(1'b1, v); check("R3 unused bits zero", v, 32'h0);
        wr(1'b1, 32'h0300_0201);

        wp_mask = 12'h004;
        prog(18'h00004, 2'd2);
        expect_start("R7 good program", 1, 2'd1, 4'd0);
        done_pulse();
        rd(1'b0, v); check("R9 completion flag", v, 32'h1);
        wr(1'b0, 32'h0);
        rd(1'b0, v); check("R10 write 0 keeps", v, 32'h1);
        wr(1'b0, 32'h1);
        rd(1'b0, v); check("R10 write 1 clears", v, 32'h0);

        prog(18'h00010, 2'd0);
        expect_start("R4 width mismatch", 0, 2'd0, 4'd0);
        rd(1'b0, v); check("R4 R8 width flags", v, 32'h42);
        clear_all();

        prog(18'h0000E, 2'd2);
        expect_start("R5 row overflow", 0, 2'd0, 4'd0);
        rd(1'b0, v); check("R5 row flags", v, 32'h22);
        clear_all();
        prog(18'h0000C, 2'd2);
        expect_start("R5 row boundary", 1, 2'd1, 4'd0);
        prog(18'h00020, 2'd2);
        expect_start("R7 busy ignores", 0, 2'd0, 4'd0);
        done_pulse();
        clear_all();

        prog(18'h08000, 2'd2);
        expect_start("R6 protected sector", 0, 2'd0, 4'd0);
        rd(1'b0, v); check("R6 protect flags", v, 32'h12);
        clear_all();
        prog(18'h30000, 2'd2);
        expect_start("R6 absent sector", 0, 2'd0, 4'd0);
        rd(1'b0, v); check("R6 absent flags", v, 32'h12);
        clear_all();
        prog(18'h04008, 2'd2);
        expect_start("R7 sector one", 1, 2'd1, 4'd1);
        done_pulse();
        clear_all();

        wr(1'b1, 32'h0100_0201);
        prog(18'h00010, 2'd0);
        rd(1'b0, v); check("R8 no rej flag without enable", v, 32'h40);
        clear_all();

        wr(1'b1, 32'h0000_0201);
        prog(18'h00020, 2'd2);
        expect_start("R9 program", 1, 2'd1, 4'd0);
        done_pulse();
        rd(1'b0, v); check("R9 no flag without enable", v, 32'h0);

        wr(1'b1, 32'h0301_001A);
        expect_start("R12 sector erase", 1, 2'd2, 4'd3);
        rd(1'b1, v); check("R12 start held busy", v, 32'h0301_001A);
        done_pulse();
        rd(1'b1, v); check("R12 start cleared at end", v, 32'h0300_001A);
        rd(1'b0, v); check("R12 erase completion", v, 32'h1);
        clear_all();

        wr(1'b1, 32'h0301_0012);
        expect_start("R12 erase on protected", 0, 2'd0, 4'd0);
        rd(1'b0, v); check("R6 erase protect flags", v, 32'h12);
        rd(1'b1, v); check("R12 start cleared on reject", v, 32'h0300_0012);
        clear_all();

        wr(1'b1, 32'h0301_0004);
        expect_start("R6 mass erase blocked", 0, 2'd0, 4'd0);
        rd(1'b0, v); check("R6 mass protect flags", v, 32'h12);
        clear_all();
        wp_mask = 12'h000;
        wr(1'b1, 32'h0301_001E);
        expect_start("R12 mass over sector", 1, 2'd3, 4'd0);
        done_pulse();
        clear_all();

        wr(1'b1, 32'h0300_0200);
        prog(18'h00000, 2'd2);
        expect_start("R13 program disabled", 0, 2'd0, 4'd0);
        rd(1'b0, v); check("R13 no flags", v, 32'h0);

        wr(1'b1, 32'h0300_0201);
        prog(18'h00040, 2'd2);
        expect_start("R10 collision setup", 1, 2'd1, 4'd0);
        @(posedge clk); #1;
        arr_done = 1; reg_wr = 1; reg_addr = 0; reg_wdata = 32'h1;
        @(posedge clk); #1;
        arr_done = 0; reg_wr = 0;
        rd(1'b0, v); check("R10 set wins over clear", v, 32'h1);
        clear_all();

        wr(1'b1, 32'h8300_0201);
        rd(1'b1, v); check("R2 relock", v, 32'h8300_0201);
        prog(18'h00000, 2'd2);
        expect_start("R2 program while locked", 0, 2'd0, 4'd0);
        wr(1'b1, 32'h0);
        rd(1'b1, v); check("R2 write after relock", v, 32'h8300_0201);
        rd(1'b0, v); check("R11 status clean", v, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule